// File: doc/BRIEF.md
# XGMII Compliance Test Frame Generator

This block drives a 32-bit XGMII transmit bus, four data bytes and four control bits per clock, with an endless train of identical Ethernet-framed test packets. Each packet opens with a start character and a preamble, closes with the start-of-frame delimiter, and then carries a fixed payload. A CRC-32 computed in hardware over the payload follows, then a terminate character, then idle characters that make up the inter-packet gap. A mode input picks the payload. One choice is a pseudo-random content pattern. The other is a jitter-stress pattern that swaps long runs of a low-transition byte for stretches of high-transition bytes, to disturb a downstream clock recovery loop.

The enable and mode inputs are sampled only in the inter-packet gap, when a new packet is about to start. So the transmit bus only ever carries whole packets. A loopback input copies the transmit bus onto the receive outputs through one register stage. When loopback is off, the receive side shows idles.

Top module: `xgmii_testpkt_gen`

## Requirements
- R1: While reset is asserted, and in the first clock after it, txd is 0x07070707 with txc=0xF, and rxd/rxc show the same idle word.
- R2: The first word of each packet is 0x555555FB with txc=0x1. This places start character 0xFB on lane 0 (txd[7:0]), where lane k is txd[8k+7:8k], and 0x55 on lanes 1 to 3.
- R3: The word after a start word is always 0xD5555555 with txc=0x0: preamble 0x55 on lanes 0 to 2 and delimiter 0xD5 on lane 3.
- R4: With mode=0 the payload is 372 words (1488 bytes) with txc=0x0, each word repeating one byte on all lanes. Word 0 is 0xBE, word 1 is 0xD7, word 2 is 0x23 and word 371 is 0x59. Words 3 to 370 take successive values of an 8-bit register seeded with 0x47 that steps as x -> (x<<1) XOR (0x1D if x[7] was set).
- R5: With mode=1 the payload is 376 words (1504 bytes) with txc=0x0. Word 0 is 0x7E7E7E0B. Then come 131 words of 0x7E, then 160 words alternating 0xF4 and 0xEB starting with 0xF4, then 42 words of 0x7E, then 42 words alternating 0xF4/0xEB starting with 0xF4. Each payload byte fills all four lanes of its word.
- R6: The word after the last payload word is the Ethernet CRC-32 of the payload bytes, taken in lane order 0 to 3 within each word. The CRC uses the reflected polynomial 0x04C11DB7, starts from all ones and is inverted at the end. Its least significant byte goes on lane 0, and txc=0x0.
- R7: The word after the CRC is 0x070707FD with txc=0xF.
- R8: After each terminate word exactly two idle words (0x07070707, txc=0xF) follow before the next start word while enable stays high, so the gap is at least 12 bytes including the terminate character.
- R9: A change of mode or a drop of enable during a packet has no effect on that packet; it completes with the pattern selected at its start.
- R10: When loopback_en was high at a clock edge, rxd/rxc after that edge equal txd/txc before it; when it was low, rxd/rxc are 0x07070707/0xF.
- R11: While enable is low, outside a packet already under way, only idle words are sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start packets when high (sampled in the gap) |
| mode_sel | input | 1 | 0: random-content payload, 1: jitter-stress payload |
| loopback_en | input | 1 | Copy the transmit bus to the receive outputs |
| txd | output | 32 | XGMII transmit data, lane k on bits 8k+7:8k |
| txc | output | 4 | XGMII transmit control, one bit per lane |
| rxd | output | 32 | XGMII receive data (loopback copy or idles) |
| rxc | output | 4 | XGMII receive control |

## Verification
The hardest case to reach from the ports is a mode flip or an enable drop that lands inside a packet. That packet must still finish with its original payload and CRC, and the next decision must fall exactly at the second gap word. The stimulus changes mode_sel and enable at fixed cycle offsets that fall deep inside packets of both kinds. The reference model then labels every word sent while the inputs disagree with the packet's own mode. Loopback is also switched on and off in the middle of packets, so that the receive copy is checked across both payload types.

// File: rtl/xtp_pkg.sv
package xtp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SFD,
        ST_PAY,
        ST_FCS,
        ST_TERM
    } xtp_state_e;

    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CH_PRE   = 8'h55;
    localparam logic [7:0] CH_SFD   = 8'hD5;

    localparam logic [31:0] IDLE_WORD = {4{CH_IDLE}};
    localparam logic [3:0]  CTL_ALL   = 4'hF;

    // payload run segment: even-count word uses lo_byte, odd-count word hi_byte
    typedef struct packed {
        logic [7:0] lo_byte;
        logic [7:0] hi_byte;
        logic [9:0] words;
    } seg_t;

    // reflected CRC-32 step over one 32-bit word, lane 0 byte first
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [31:0] data);
        logic [31:0] c;
        c = crc_in;
        for (int i = 0; i < 32; i++) begin
            if (c[0] ^ data[i]) begin
                c = (c >> 1) ^ 32'hEDB88320;
            end else begin
                c = c >> 1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/xtp_payload_gen.sv
module xtp_payload_gen
    import xtp_pkg::*;
#(
    parameter int RC_BYTES = 1488,
    parameter int JT_BYTES = 1504
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        step,
    input  logic        jitter,
    output logic [31:0] word,
    output logic        last
);

    localparam int RC_WORDS = RC_BYTES / 4;
    localparam int JT_WORDS = JT_BYTES / 4;
    localparam int MAX_WORDS = (RC_WORDS > JT_WORDS) ? RC_WORDS : JT_WORDS;
    localparam int IDXW = $clog2(MAX_WORDS + 1);
    localparam int JT_HEAD = 1 + 131 + 160 + 42;
    localparam int JT_TAIL = JT_WORDS - JT_HEAD;
    localparam int NSEG = 5;
    localparam int SEGW = $clog2(NSEG + 1);
    localparam logic [IDXW-1:0] RC_LAST = IDXW'(RC_WORDS - 1);
    localparam logic [IDXW-1:0] JT_LAST = IDXW'(JT_WORDS - 1);
    localparam logic [7:0] LFSR_SEED = 8'h47;

    typedef struct packed {
        logic [IDXW-1:0] idx;
        logic [7:0]      lfsr;
        logic [SEGW-1:0] seg;
        logic [9:0]      seg_cnt;
    } pg_regs_t;

    pg_regs_t r_q, r_d;

    function automatic seg_t seg_at(input logic [SEGW-1:0] s);
        seg_t e;
        case (s)
            SEGW'(0): e = '{lo_byte: 8'h7E, hi_byte: 8'h7E, words: 10'd1};
            SEGW'(1): e = '{lo_byte: 8'h7E, hi_byte: 8'h7E, words: 10'd131};
            SEGW'(2): e = '{lo_byte: 8'hF4, hi_byte: 8'hEB, words: 10'd160};
            SEGW'(3): e = '{lo_byte: 8'h7E, hi_byte: 8'h7E, words: 10'd42};
            SEGW'(4): e = '{lo_byte: 8'hF4, hi_byte: 8'hEB, words: 10'(JT_TAIL)};
            default:  e = '{lo_byte: 8'h7E, hi_byte: 8'h7E, words: 10'd1};
        endcase
        return e;
    endfunction

    seg_t       cur_seg;
    logic [7:0] rc_byte;
    logic [7:0] jt_byte;

    always_comb begin
        cur_seg = seg_at(r_q.seg);
        jt_byte = r_q.seg_cnt[0] ? cur_seg.hi_byte : cur_seg.lo_byte;

        if (r_q.idx == IDXW'(0)) begin
            rc_byte = 8'hBE;
        end else if (r_q.idx == IDXW'(1)) begin
            rc_byte = 8'hD7;
        end else if (r_q.idx == IDXW'(2)) begin
            rc_byte = 8'h23;
        end else if (r_q.idx == RC_LAST) begin
            rc_byte = 8'h59;
        end else begin
            rc_byte = r_q.lfsr;
        end

        if (jitter) begin
            word = {4{jt_byte}};
            if (r_q.idx == IDXW'(0)) begin
                word[7:0] = 8'h0B;
            end
            last = (r_q.idx == JT_LAST);
        end else begin
            word = {4{rc_byte}};
            last = (r_q.idx == RC_LAST);
        end

        r_d = r_q;
        if (restart) begin
            r_d.idx     = '0;
            r_d.lfsr    = LFSR_SEED;
            r_d.seg     = '0;
            r_d.seg_cnt = '0;
        end else if (step) begin
            r_d.idx = r_q.idx + IDXW'(1);
            if (r_q.idx >= IDXW'(3)) begin
                r_d.lfsr = {r_q.lfsr[6:0], 1'b0} ^ (r_q.lfsr[7] ? 8'h1D : 8'h00);
            end
            if (r_q.seg_cnt == cur_seg.words - 10'd1) begin
                r_d.seg     = r_q.seg + SEGW'(1);
                r_d.seg_cnt = '0;
            end else begin
                r_d.seg_cnt = r_q.seg_cnt + 10'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{idx: '0, lfsr: LFSR_SEED, seg: '0, seg_cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R4 / R5: payload never runs past its own length
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (r_q.idx < (jitter ? IDXW'(JT_WORDS) : IDXW'(RC_WORDS))))
        else $error("payload index overrun");

    // R4: pseudo-random register never sticks at zero
    p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lfsr != 8'h00)
        else $error("payload register collapsed to zero");

endmodule

// File: rtl/xtp_fcs.sv
module xtp_fcs
    import xtp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        update,
    input  logic [31:0] data,
    output logic [31:0] fcs
);

    logic [31:0] crc_q, crc_d;

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = '1;
        end else if (update) begin
            crc_d = crc32_step(crc_q, data);
        end
        fcs = ~crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else begin
            crc_q <= crc_d;
        end
    end

    // R6: accumulator holds still unless payload is flowing or a packet opens
    p_crc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !update) |=> $stable(crc_q))
        else $error("crc changed without payload");

endmodule

// File: rtl/xtp_rx_loop.sv
module xtp_rx_loop
    import xtp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        loop_en,
    input  logic [31:0] txd,
    input  logic [3:0]  txc,
    output logic [31:0] rxd,
    output logic [3:0]  rxc
);

    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  c;
    } rx_regs_t;

    rx_regs_t r_q, r_d;

    always_comb begin
        if (loop_en) begin
            r_d = '{d: txd, c: txc};
        end else begin
            r_d = '{d: IDLE_WORD, c: CTL_ALL};
        end
        rxd = r_q.d;
        rxc = r_q.c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{d: IDLE_WORD, c: CTL_ALL};
        end else begin
            r_q <= r_d;
        end
    end

    p_loop_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |=> (rxd == $past(txd)) && (rxc == $past(txc)))
        else $error("loopback copy mismatch");

    p_loop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> (rxd == IDLE_WORD) && (rxc == CTL_ALL))
        else $error("receive side not idle with loopback off");

endmodule

// File: rtl/xgmii_testpkt_gen.sv
module xgmii_testpkt_gen
    import xtp_pkg::*;
#(
    parameter int RC_BYTES   = 1488,
    parameter int JT_BYTES   = 1504,
    parameter int IDLE_WORDS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        mode_sel,
    input  logic        loopback_en,
    output logic [31:0] txd,
    output logic [3:0]  txc,
    output logic [31:0] rxd,
    output logic [3:0]  rxc
);

    localparam int GAPW = (IDLE_WORDS > 1) ? $clog2(IDLE_WORDS) : 1;
    localparam logic [GAPW-1:0] GAP_MAX = GAPW'(IDLE_WORDS - 1);

    typedef struct packed {
        xtp_state_e      state;
        logic [GAPW-1:0] gap;
        logic            jitter;
    } ctl_regs_t;

    ctl_regs_t r_q, r_d;

    logic [31:0] pay_word;
    logic        pay_last;
    logic [31:0] fcs;
    logic        pg_restart;
    logic        pg_step;
    logic        crc_clear;

    xtp_payload_gen #(
        .RC_BYTES(RC_BYTES),
        .JT_BYTES(JT_BYTES)
    ) u_payload (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(pg_restart),
        .step   (pg_step),
        .jitter (r_q.jitter),
        .word   (pay_word),
        .last   (pay_last)
    );

    xtp_fcs u_fcs (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .update(pg_step),
        .data  (pay_word),
        .fcs   (fcs)
    );

    xtp_rx_loop u_loop (
        .clk    (clk),
        .rst_n  (rst_n),
        .loop_en(loopback_en),
        .txd    (txd),
        .txc    (txc),
        .rxd    (rxd),
        .rxc    (rxc)
    );

    always_comb begin
        r_d        = r_q;
        pg_restart = 1'b0;
        pg_step    = 1'b0;
        crc_clear  = 1'b0;
        txd        = IDLE_WORD;
        txc        = CTL_ALL;

        case (r_q.state)
            ST_IDLE: begin
                if (r_q.gap == GAP_MAX && enable) begin
                    r_d.state  = ST_START;
                    r_d.jitter = mode_sel;
                end else if (r_q.gap != GAP_MAX) begin
                    r_d.gap = r_q.gap + GAPW'(1);
                end
            end
            ST_START: begin
                txd       = {CH_PRE, CH_PRE, CH_PRE, CH_START};
                txc       = 4'h1;
                crc_clear = 1'b1;
                r_d.state = ST_SFD;
            end
            ST_SFD: begin
                txd        = {CH_SFD, CH_PRE, CH_PRE, CH_PRE};
                txc        = 4'h0;
                pg_restart = 1'b1;
                r_d.state  = ST_PAY;
            end
            ST_PAY: begin
                txd     = pay_word;
                txc     = 4'h0;
                pg_step = 1'b1;
                if (pay_last) begin
                    r_d.state = ST_FCS;
                end
            end
            ST_FCS: begin
                txd       = fcs;
                txc       = 4'h0;
                r_d.state = ST_TERM;
            end
            ST_TERM: begin
                txd       = {CH_IDLE, CH_IDLE, CH_IDLE, CH_TERM};
                txc       = CTL_ALL;
                r_d.state = ST_IDLE;
                r_d.gap   = '0;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.gap   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, gap: '0, jitter: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    p_sfd_follows_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (txc == 4'h1) |=> (txd == 32'hD5555555) && (txc == 4'h0))
        else $error("delimiter word missing after start");

    p_start_lane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (txc == 4'h1) |-> (txd[7:0] == CH_START))
        else $error("start character off lane 0");

    p_term_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txc == CTL_ALL && txd[7:0] == CH_TERM) |=> (txd == IDLE_WORD) && (txc == CTL_ALL))
        else $error("terminate not followed by idle");

    p_start_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (txc == 4'h1) |-> ($past(txd) == IDLE_WORD) && ($past(txc) == CTL_ALL))
        else $error("start word without preceding gap");

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE && $past(r_q.state) != ST_IDLE) |-> $stable(r_q.jitter))
        else $error("payload mode changed inside a packet");

    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && r_q.state == ST_IDLE) |=> (txd == IDLE_WORD) && (txc == CTL_ALL))
        else $error("packet started while disabled");

endmodule

// File: tb/xgmii_testpkt_gen_test.sv
module xgmii_testpkt_gen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        mode_sel;
    logic        loopback_en;
    logic [31:0] txd;
    logic [3:0]  txc;
    logic [31:0] rxd;
    logic [3:0]  rxc;

    always #5 clk = ~clk;

    xgmii_testpkt_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .mode_sel   (mode_sel),
        .loopback_en(loopback_en),
        .txd        (txd),
        .txc        (txc),
        .rxd        (rxd),
        .rxc        (rxc)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [35:0] exp_q[$];
    string       tag_q[$];
    logic [35:0] cur_exp = {4'hF, 32'h07070707};
    string       cur_tag = "R1";
    int          idle_run = 1;
    bit          frame_jit = 0;
    bit          prev_lb = 0;
    logic [31:0] prev_txd = 32'h07070707;
    logic [3:0]  prev_txc = 4'hF;

    function automatic logic [31:0] ref_crc(input logic [7:0] bytes[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (bytes[k]) begin
            for (int b = 0; b < 8; b++) begin
                bit mix = c[0] ^ bytes[k][b];
                c = {1'b0, c[31:1]};
                if (mix) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic push_word(input logic [3:0] c, input logic [31:0] d, input string t);
        exp_q.push_back({c, d});
        tag_q.push_back(t);
    endtask

    task automatic build_frame(input bit jit);
        logic [7:0]  bytes[$];
        logic [31:0] w;
        logic [7:0]  lf = 8'h47;
        push_word(4'h1, 32'h555555FB, "R2");
        push_word(4'h0, 32'hD5555555, "R3");
        if (!jit) begin
            for (int i = 0; i < 372; i++) begin
                logic [7:0] v;
                if (i == 0) v = 8'hBE;
                else if (i == 1) v = 8'hD7;
                else if (i == 2) v = 8'h23;
                else if (i == 371) v = 8'h59;
                else begin
                    v = lf;
                    lf = (lf << 1) ^ (lf[7] ? 8'h1D : 8'h00);
                end
                w = {v, v, v, v};
                push_word(4'h0, w, "R4");
                for (int k = 0; k < 4; k++) bytes.push_back(w[8*k +: 8]);
            end
        end else begin
            for (int i = 0; i < 376; i++) begin
                logic [7:0] v;
                if (i < 132) v = 8'h7E;
                else if (i < 292) v = ((i - 132) % 2 == 0) ? 8'hF4 : 8'hEB;
                else if (i < 334) v = 8'h7E;
                else v = ((i - 334) % 2 == 0) ? 8'hF4 : 8'hEB;
                w = {v, v, v, v};
                if (i == 0) w[7:0] = 8'h0B;
                push_word(4'h0, w, "R5");
                for (int k = 0; k < 4; k++) bytes.push_back(w[8*k +: 8]);
            end
        end
        push_word(4'h0, ref_crc(bytes), "R6");
        push_word(4'hF, 32'h070707FD, "R7");
    endtask

    // reference model: decides the word each edge produces
    always @(posedge clk) begin
        if (rst_n) begin
            prev_lb = loopback_en;
            if (exp_q.size() == 0) begin
                if (idle_run >= 2 && enable) begin
                    frame_jit = mode_sel;
                    build_frame(mode_sel);
                end else begin
                    cur_exp = {4'hF, 32'h07070707};
                    cur_tag = enable ? "R8" : "R11";
                    idle_run++;
                end
            end
            if (exp_q.size() != 0) begin
                cur_exp = exp_q.pop_front();
                cur_tag = tag_q.pop_front();
                if (cur_exp == {4'hF, 32'h070707FD}) idle_run = 0;
                if ((cur_tag == "R4" || cur_tag == "R5" || cur_tag == "R6") &&
                    (mode_sel != frame_jit || !enable)) cur_tag = "R9";
            end
        end else begin
            prev_lb = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            logic [31:0] er_d;
            logic [3:0]  er_c;
            n_checks++;
            if ({txc, txd} !== cur_exp) begin
                n_fail++;
                $display("FAIL %s tx: actual txc=%h txd=%h expected txc=%h txd=%h",
                         cur_tag, txc, txd, cur_exp[35:32], cur_exp[31:0]);
            end
            er_d = prev_lb ? prev_txd : 32'h07070707;
            er_c = prev_lb ? prev_txc : 4'hF;
            n_checks++;
            if ({rxc, rxd} !== {er_c, er_d}) begin
                n_fail++;
                $display("FAIL %s rx: actual rxc=%h rxd=%h expected rxc=%h rxd=%h",
                         rst_n ? "R10" : "R1", rxc, rxd, er_c, er_d);
            end
            prev_txd = txd;
            prev_txc = txc;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0;
        enable = 1'b0;
        mode_sel = 1'b0;
        loopback_en = 1'b0;
        wait_cycles(4);                 // R1 reset state
        rst_n = 1'b1;
        wait_cycles(6);                 // R11 idles while disabled
        enable = 1'b1;
        loopback_en = 1'b1;             // R10 loopback on
        wait_cycles(600);               // R4 random frames, R8 gaps
        mode_sel = 1'b1;                // R9 flip inside a packet
        wait_cycles(500);
        loopback_en = 1'b0;             // R10 off mid-packet
        wait_cycles(250);
        loopback_en = 1'b1;
        wait_cycles(300);               // R5 jitter frames
        enable = 1'b0;                  // R9 drop inside a packet
        wait_cycles(500);               // R11
        enable = 1'b1;
        mode_sel = 1'b0;
        wait_cycles(200);
        mode_sel = 1'b1;                // R9 flip inside random packet
        wait_cycles(900);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule